// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache with Posted Store Queue

This block is a small data cache that sits between a 32-bit load/store unit and a plain memory port. Each set holds two blocks of eight 32-bit words. The set index picks one set, and both tags in that set are compared with the request at the same time. On a hit the matching way supplies the data. On a load miss the block is fetched one word per beat. The way that was used less recently is overwritten, and the requested word is returned at the end of the refill.

Stores use a write-through, no-allocate policy. Every store is placed in a four-entry first-in first-out queue that drains to memory in order. When the store hits, the cached copy is updated as well. A store that misses leaves the cache unchanged. The processor waits only when the queue is already holding four stores.

A load miss must not read memory while a queued store to the same block is still waiting. The cache holds that refill back until memory has accepted the store.

Top module: `wt_cache2w`

## Requirements
- R1: Address bits [1:0] are ignored, bits [4:2] select the word inside a 32-byte block, bits [8:5] select one of 16 sets, and bits [31:9] form the tag. A load that hits is accepted in one cycle. Its word appears on the response port in the next cycle, and no refill is requested.
- R2: Two blocks with the same set index and different tags can be resident at the same time, one in each way. A load to either of them hits and returns that block's data.
- R3: On a load miss the cache raises a read request with the block-aligned address (low 5 bits zero). It keeps the request and the address steady until granted, then takes exactly 8 beats holding words 0 to 7 in order. The response carries the requested word in the cycle after the last beat. No new request is accepted while this happens.
- R4: Each set has one recency bit that points at the way not used most recently. A hit or a refill sets it to the other way, and a miss replaces the way it points at.
- R5: A store that hits writes its data into the cached word and is also queued for memory. Later loads to that word hit and return the new data.
- R6: A store that misses changes no tag, valid bit or recency bit. A later load to that address misses and returns the stored value.
- R7: Queued stores go out on the write port in the order they were accepted, each with its address and data. The port holds valid, address and data steady until memory accepts them.
- R8: While four stores are queued, a store request is not accepted until an entry drains. A load is still accepted.
- R9: A load miss whose block matches a queued store does not raise the read request until memory has accepted every such store.
- R10: Each accepted load produces exactly one response pulse. A store produces none.
- R11: After reset every block is invalid, the queue is empty, the cache is ready for a request, and no read, write or response is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request present |
| reqWrite | input | 1 | Request is a store (1) or a load (0) |
| reqAddr | input | 32 | Byte address of the request |
| reqWdata | input | 32 | Store data |
| reqReady | output | 1 | Request accepted at this edge when reqValid is high |
| rspValid | output | 1 | One-cycle pulse carrying load data |
| rspData | output | 32 | Load result |
| memRdReq | output | 1 | Block refill request |
| memRdAddr | output | 32 | Block-aligned refill address |
| memRdGnt | input | 1 | Memory accepts the refill request |
| memRdBeat | input | 1 | One refill word is present |
| memRdData | input | 32 | Refill word, word 0 first |
| memWrValid | output | 1 | A queued store is offered |
| memWrAddr | output | 32 | Address of the offered store |
| memWrData | output | 32 | Data of the offered store |
| memWrReady | input | 1 | Memory takes the offered store |

## Verification
The assertions assume the following about the memory side: it grants a read only while the request is raised, it sends beats only after the grant, and it sends exactly eight beats per grant. They also assume the processor uses word-aligned addresses and holds a request until it is accepted. The bench memory model follows all of these rules. It grants immediately, leaves one idle cycle, and inserts a single bubble before the fourth beat. The processor driver keeps at most one request open, so loads and stores never overlap.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_ASK, ST_FILL} wtcState_t;

  typedef struct packed {
    logic capture;   // latch miss address and victim way
    logic loadHit;   // return hit word, touch recency
    logic storeHit;  // write word in hit way, touch recency
    logic fillBeat;  // write one refill word
    logic fillDone;  // install tag and valid, touch recency
  } wtcStrobe_t;
endpackage

// File: rtl/wtc_wbuf.sv
`timescale 1ns/1ps
module wtc_wbuf #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4,
  parameter int BLK_LSB = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic              full,
  output logic              headValid,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              conflict
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [DEPTH-1:0]  live;
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [DEPTH-1:0]  matchVec;
  logic              unusedProbe;

  assign unusedProbe = ^probeAddr[BLK_LSB-1:0];
  assign full      = live[wrPtr];
  assign headValid = live[rdPtr];
  assign headAddr  = addrQ[rdPtr];
  assign headData  = dataQ[rdPtr];

  for (genvar e = 0; e < DEPTH; e++) begin : g_probe
    assign matchVec[e] = live[e] &&
      (addrQ[e][ADDR_W-1:BLK_LSB] == probeAddr[ADDR_W-1:BLK_LSB]);
  end
  assign conflict = |matchVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      live  <= '0;
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (pop) begin
        live[rdPtr] <= 1'b0;
        rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      end
      if (push) begin
        live[wrPtr] <= 1'b1;
        wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addrQ[wrPtr] <= pushAddr;
      dataQ[wrPtr] <= pushData;
    end
  end
endmodule

// File: rtl/wtc_data.sv
`timescale 1ns/1ps
module wtc_data import wtc_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 16,
  parameter int WORDS  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wtcStrobe_t               strobe,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        beatData,
  input  logic [$clog2(WORDS)-1:0] beatIdx,
  output logic                     hit,
  output logic [DATA_W-1:0]        rspData,
  output logic [ADDR_W-1:0]        missAddr
);
  localparam int WAYS   = 2;
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

  logic [TAG_W-1:0]  tagArr  [WAYS][SETS];
  logic [DATA_W-1:0] dataArr [WAYS][SETS][WORDS];
  logic [SETS-1:0]   valid   [WAYS];
  logic [SETS-1:0]   lruBit;

  logic [IDX_W-1:0]  idx, cIdx;
  logic [TAG_W-1:0]  tag, cTag;
  logic [WSEL_W-1:0] wsel, cWsel;
  logic [WAYS-1:0]   wayMatch;
  logic              hitWay, capWay;
  logic [DATA_W-1:0] hitData;
  logic              unusedLow;

  assign unusedLow = ^reqAddr[BYTE_W-1:0];
  assign idx  = reqAddr[OFF_W +: IDX_W];
  assign tag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign wsel = reqAddr[BYTE_W +: WSEL_W];
  assign cIdx  = missAddr[OFF_W +: IDX_W];
  assign cTag  = missAddr[ADDR_W-1 -: TAG_W];
  assign cWsel = missAddr[BYTE_W +: WSEL_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayMatch[w] = valid[w][idx] && (tagArr[w][idx] == tag);
  end
  assign hit     = |wayMatch;
  assign hitWay  = wayMatch[1];
  assign hitData = dataArr[hitWay][idx][wsel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) valid[w] <= '0;
      lruBit   <= '0;
      missAddr <= '0;
      capWay   <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobe.capture) begin
        missAddr <= reqAddr;
        capWay   <= lruBit[idx];
      end
      if (strobe.loadHit) begin
        rspData     <= hitData;
        lruBit[idx] <= ~hitWay;
      end
      if (strobe.storeHit) lruBit[idx] <= ~hitWay;
      if (strobe.fillBeat && (beatIdx == cWsel)) rspData <= beatData;
      if (strobe.fillDone) begin
        valid[capWay][cIdx] <= 1'b1;
        lruBit[cIdx]        <= ~capWay;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.storeHit) dataArr[hitWay][idx][wsel] <= reqWdata;
    if (strobe.fillBeat) dataArr[capWay][cIdx][beatIdx] <= beatData;
    if (strobe.fillDone) tagArr[capWay][cIdx] <= cTag;
  end
endmodule

// File: rtl/wtc_ctrl.sv
`timescale 1ns/1ps
module wtc_ctrl import wtc_pkg::*; #(
  parameter int WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic                     hit,
  input  logic                     wbFull,
  input  logic                     wbConflict,
  input  logic                     memRdGnt,
  input  logic                     memRdBeat,
  output logic                     reqReady,
  output wtcStrobe_t               strobe,
  output logic                     wbPush,
  output logic                     memRdReq,
  output logic [$clog2(WORDS)-1:0] beatIdx,
  output logic                     rspValid
);
  localparam int WSEL_W = $clog2(WORDS);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  wtcState_t state, nextState;
  logic      accept;

  assign reqReady = (state == ST_IDLE) && !(reqWrite && wbFull);
  assign accept   = reqValid && reqReady;
  assign wbPush   = accept && reqWrite;
  assign memRdReq = (state == ST_ASK);

  always_comb begin
    strobe          = '0;
    strobe.capture  = accept && !reqWrite && !hit;
    strobe.loadHit  = accept && !reqWrite && hit;
    strobe.storeHit = accept && reqWrite && hit;
    strobe.fillBeat = (state == ST_FILL) && memRdBeat;
    strobe.fillDone = strobe.fillBeat && (beatIdx == LAST_BEAT);
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: if (strobe.capture)  nextState = ST_HOLD;
      ST_HOLD: if (!wbConflict)     nextState = ST_ASK;
      ST_ASK:  if (memRdGnt)        nextState = ST_FILL;
      ST_FILL: if (strobe.fillDone) nextState = ST_IDLE;
      default:                      nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      beatIdx  <= '0;
      rspValid <= 1'b0;
    end else begin
      state    <= nextState;
      rspValid <= strobe.loadHit || strobe.fillDone;
      if (state != ST_FILL)     beatIdx <= '0;
      else if (strobe.fillBeat) beatIdx <= beatIdx + 1'b1;
    end
  end
endmodule

// File: rtl/wt_cache2w.sv
`timescale 1ns/1ps
module wt_cache2w import wtc_pkg::*; #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SETS     = 16,
  parameter int WORDS    = 8,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdGnt,
  input  logic              memRdBeat,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memWrReady
);
  localparam int OFF_W  = $clog2(DATA_W / 8) + $clog2(WORDS);
  localparam int WSEL_W = $clog2(WORDS);

  wtcStrobe_t        strobe;
  logic              hit, wbFull, wbConflict, wbPush;
  logic [WSEL_W-1:0] beatIdx;
  logic [ADDR_W-1:0] missAddr;

  assign memRdAddr = {missAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  wtc_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .hit(hit), .wbFull(wbFull), .wbConflict(wbConflict),
    .memRdGnt(memRdGnt), .memRdBeat(memRdBeat), .reqReady(reqReady),
    .strobe(strobe), .wbPush(wbPush), .memRdReq(memRdReq),
    .beatIdx(beatIdx), .rspValid(rspValid)
  );

  wtc_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .beatData(memRdData), .beatIdx(beatIdx),
    .hit(hit), .rspData(rspData), .missAddr(missAddr)
  );

  wtc_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH), .BLK_LSB(OFF_W)) u_wbuf (
    .clk(clk), .rstN(rstN), .push(wbPush), .pushAddr(reqAddr),
    .pushData(reqWdata), .pop(memWrValid && memWrReady), .full(wbFull),
    .headValid(memWrValid), .headAddr(memWrAddr), .headData(memWrData),
    .probeAddr(missAddr), .conflict(wbConflict)
  );
endmodule

// File: rtl/wtc_checker.sv
`timescale 1ns/1ps
module wtc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqReady,
  input logic              wbFull,
  input logic              wbConflict,
  input logic              memRdReq,
  input logic              memRdGnt,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memWrValid,
  input logic              memWrReady,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              rspValid
);
  a_r8_full_blocks_store: assert property (@(posedge clk) disable iff (!rstN)
    (wbFull && reqWrite) |-> !reqReady);

  a_r9_no_read_on_conflict: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> !wbConflict);

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdGnt) |=> (memRdReq && $stable(memRdAddr)));

  a_r3_busy_during_refill: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> !reqReady);

  a_r7_write_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && !memWrReady) |=> (memWrValid && $stable(memWrAddr) && $stable(memWrData)));

  a_r10_no_rsp_for_store: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> !rspValid);
endmodule

bind wt_cache2w wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqReady(reqReady), .wbFull(wbFull), .wbConflict(wbConflict),
  .memRdReq(memRdReq), .memRdGnt(memRdGnt), .memRdAddr(memRdAddr),
  .memWrValid(memWrValid), .memWrReady(memWrReady), .memWrAddr(memWrAddr),
  .memWrData(memWrData), .rspValid(rspValid)
);

// File: tb/sim_wt_cache2w.sv
`timescale 1ns/1ps
module sim_wt_cache2w;
  localparam int SETS = 16, WORDS = 8, WBD = 4, LIMIT = 150000;

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic reqValid = 0, reqWrite = 0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic memRdGnt = 0, memRdBeat = 0, memWrReady = 0;
  logic [31:0] memRdData = '0;
  logic reqReady, rspValid, memRdReq, memWrValid;
  logic [31:0] rspData, memRdAddr, memWrAddr, memWrData;

  wt_cache2w u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdGnt(memRdGnt), .memRdBeat(memRdBeat),
    .memRdData(memRdData), .memWrValid(memWrValid), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrReady(memWrReady)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit timedOut = 0, wrStall = 0, randMode = 0, acceptedNow = 0;
  string curTag = "R1";

  logic [31:0] progMem [logic [31:0]];
  logic [31:0] physMem [logic [31:0]];
  logic [63:0] wq [$];
  logic [22:0] rTag [2][SETS];
  bit rVal [2][SETS];
  bit rLru [SETS];

  bit loadPending = 0, expMiss = 0;
  logic [31:0] expData, loadAddr;
  int grants = 0, acceptCyc = 0, lastBeatCyc = 0;

  int rdPhase = 0, beatK = 0;
  bit skipped = 0;
  logic [31:0] rdBlk;

  function automatic logic [31:0] initVal(logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] progRd(logic [31:0] a);
    return progMem.exists(a) ? progMem[a] : initVal(a);
  endfunction
  function automatic logic [31:0] physRd(logic [31:0] a);
    return physMem.exists(a) ? physMem[a] : initVal(a);
  endfunction
  function automatic int refWay(logic [31:0] a);
    for (int w = 0; w < 2; w++)
      if (rVal[w][a[8:5]] && rTag[w][a[8:5]] == a[31:9]) return w;
    return -1;
  endfunction

  task automatic check(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic evaluate();
    bit conf;
    int w;
    acceptedNow = reqValid && reqReady;
    if (reqValid && reqWrite && wq.size() == WBD)
      check(!reqReady, "R8", {31'b0, reqReady}, 32'd0);
    if (memRdGnt) begin
      conf = 0;
      foreach (wq[i]) if (wq[i][63:37] == memRdAddr[31:5]) conf = 1;
      check(!conf, "R9", {31'b0, conf}, 32'd0);
      check(loadPending && memRdAddr == {loadAddr[31:5], 5'b0}, "R3", memRdAddr, {loadAddr[31:5], 5'b0});
      grants++;
    end
    if (memRdBeat) lastBeatCyc = cyc;
    if (memWrValid && memWrReady) begin
      if (wq.size() == 0) check(0, "R7", memWrAddr, 32'hFFFF_FFFF);
      else begin
        check({memWrAddr, memWrData} == wq[0], "R7", memWrData, wq[0][31:0]);
        physMem[memWrAddr] = memWrData;
        void'(wq.pop_front());
      end
    end
    if (rspValid) begin
      if (!loadPending) check(0, "R10", rspData, 32'hFFFF_FFFF);
      else begin
        check(rspData == expData, curTag, rspData, expData);
        if (expMiss) begin
          check(grants == 1, "R3", grants, 1);
          check(cyc == lastBeatCyc + 1, "R3", cyc - lastBeatCyc, 1);
        end else begin
          check(grants == 0, "R1", grants, 0);
          check(cyc == acceptCyc + 1, "R1", cyc - acceptCyc, 1);
        end
        loadPending = 0;
      end
    end
    if (acceptedNow) begin
      w = refWay(reqAddr);
      if (reqWrite) begin
        wq.push_back({reqAddr, reqWdata});
        progMem[reqAddr] = reqWdata;
        if (w >= 0) rLru[reqAddr[8:5]] = (w == 0);
      end else begin
        if (loadPending) check(0, "R10", 32'd1, 32'd0);
        loadPending = 1; grants = 0; acceptCyc = cyc; loadAddr = reqAddr;
        expData = progRd(reqAddr);
        expMiss = (w < 0);
        if (w < 0) begin
          w = rLru[reqAddr[8:5]] ? 1 : 0;
          rVal[w][reqAddr[8:5]] = 1;
          rTag[w][reqAddr[8:5]] = reqAddr[31:9];
        end
        rLru[reqAddr[8:5]] = (w == 0);
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    if (cyc > LIMIT) timedOut = 1;
    memWrReady = wrStall ? 1'b0 : (randMode ? ($urandom % 3 != 0) : 1'b1);
    memRdGnt = 0; memRdBeat = 0;
    if (rdPhase == 0 && memRdReq) begin
      memRdGnt = 1; rdBlk = memRdAddr; rdPhase = 1; beatK = 0; skipped = 0;
    end else if (rdPhase == 1) rdPhase = 2;
    else if (rdPhase == 2) begin
      if (beatK == 3 && !skipped) skipped = 1;
      else begin
        memRdBeat = 1;
        memRdData = physRd(rdBlk + 32'(4 * beatK));
        beatK++;
        if (beatK == WORDS) rdPhase = 0;
      end
    end
    #1;
    evaluate();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(bit wr, logic [31:0] a, logic [31:0] d, string r);
    curTag = r;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    do cycle(); while (!acceptedNow && !timedOut);
    reqValid = 0; reqWrite = 0;
    if (!wr) while (loadPending && !timedOut) cycle();
  endtask

  task automatic drain();
    while (wq.size() != 0 && !timedOut) cycle();
  endtask

  localparam logic [31:0] A = 32'h0000_0024, B = 32'h0000_0224, C = 32'h0000_0424;
  localparam logic [31:0] D = 32'h3000_0068, E = 32'h1000_0040;

  initial begin
    for (int s = 0; s < SETS; s++) begin
      rLru[s] = 0; rVal[0][s] = 0; rVal[1][s] = 0;
    end
    repeat (4) cycle();
    rstN = 1;
    cycle();
    // R11: reset state
    check(reqReady == 1, "R11", {31'b0, reqReady}, 1);
    check(!memRdReq && !memWrValid && !rspValid, "R11",
          {29'b0, memRdReq, memWrValid, rspValid}, 0);

    issue(0, A, 0, "R3");          // cold miss, way 0
    issue(0, A, 0, "R1");          // hit
    issue(0, A + 4, 0, "R1");      // other word, hit
    issue(0, B, 0, "R2");          // same set, way 1
    issue(0, A, 0, "R2");
    issue(0, B + 28, 0, "R2");
    issue(0, A, 0, "R4");          // A most recent
    issue(0, C, 0, "R4");          // evicts B
    issue(0, A, 0, "R4");          // still hit
    issue(0, B, 0, "R4");          // miss again (evicts C)

    issue(1, A, 32'hCAFE_0001, "R5");
    issue(0, A, 0, "R5");
    drain();
    issue(1, E, 32'hBEEF_0002, "R6");
    drain();
    issue(0, E, 0, "R6");

    // R9: refill waits for matching queued store
    wrStall = 1;
    issue(1, D, 32'hDEAD_0003, "R9");
    curTag = "R9";
    reqValid = 1; reqWrite = 0; reqAddr = D;
    do cycle(); while (!acceptedNow && !timedOut);
    reqValid = 0;
    for (int k = 0; k < 12; k++) begin
      cycle();
      check(!memRdReq, "R9", {31'b0, memRdReq}, 0);
    end
    wrStall = 0;
    while (loadPending && !timedOut) cycle();

    // R8: full queue
    drain();
    wrStall = 1;
    for (int i = 0; i < WBD; i++) issue(1, 32'h2000_0000 + 32'(16 * i), 32'h7700_0000 + i, "R8");
    curTag = "R8";
    reqValid = 1; reqWrite = 1; reqAddr = 32'h2000_0100; reqWdata = 32'h7700_0099;
    for (int k = 0; k < 6; k++) begin
      cycle();
      check(!acceptedNow, "R8", {31'b0, acceptedNow}, 0);
    end
    reqValid = 0;
    issue(0, A, 0, "R8");          // load still goes through
    wrStall = 0;
    issue(1, 32'h2000_0100, 32'h7700_0099, "R8");
    drain();

    // mixed traffic
    randMode = 1;
    for (int n = 0; n < 400 && !timedOut; n++) begin
      logic [31:0] ra;
      ra = {21'b0, 2'($urandom % 4), 4'($urandom % 2), 3'($urandom % 8), 2'b0};
      issue(($urandom % 3) == 0, ra, $urandom, "R4");
    end
    randMode = 0;
    drain();
    check(wq.size() == 0, "R7", wq.size(), 0);
    if (timedOut) check(0, "R10", cyc, LIMIT);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule